// File: doc/BRIEF.md
# Serial Register Port for a Converter Control Block

This block is a serial slave that gives a host access to the control and result registers of a converter. Every exchange opens with an 8-bit command byte. The byte picks one register, the direction of the one access that follows, the power-down state and the input channel. The access that follows then shifts the chosen register MSB first. A register is 8, 16 or 24 bits wide.

The block holds all of the register storage. The setup and clock settings, the power-down flag and the channel come out as parallel outputs for the converter core. A new conversion result arrives on a parallel input, qualified by a one-cycle strobe. A data-ready output tracks whether that result has been read yet.

The serial clock and chip select are sampled by the system clock. The serial clock must therefore stay in each level for at least two system clock cycles. The serial clock idles high. The block samples input bits on its rising edges and drives output bits on its falling edges.

Top module: `serial_reg_port`

## Requirements
- R1: A command byte is MSB first, with this layout: bit7 is the start bit and must be 0, bits6:4 select the register, bit3 is the direction (0 = write, 1 = read), bit2 is power-down, and bits1:0 are the channel. While the block waits for a command, every leading 1 on the start bit is discarded and loads nothing.
- R2: Register select codes are: 0 command/status, 1 setup, 2 clock, 3 result, 4 test, 5 offset, 6 gain. A command with code 7 is ignored completely: no field changes and no access follows.
- R3: Any accepted command (code 0 to 6) loads its power-down bit onto `pwr_down` and its channel onto `chan`. A write command to code 0 opens no data access. Both outputs reset to 0.
- R4: A read of code 0 returns 8 bits. Bit7 is the live data-ready state, equal to `drdy_n`. Bits6:0 are the stored bits6:0 of the last accepted command.
- R5: Accesses shift MSB first. Codes 0, 1, 2 and 4 are 8 bits wide, code 3 is 16 bits, and codes 5 and 6 are 24 bits. Bits are sampled on rising `sclk` and driven on falling `sclk`.
- R6: The setup register resets to 0x01; bit0 is the conversion-start bit. The setup register is read/write and appears on `setup_cfg`.
- R7: In the clock register, bit4 is an identifier that always reads 1 and ignores writes. The other bits are read/write. The register resets to 0x10 and appears on `clock_cfg`.
- R8: A `res_valid` pulse loads `res_in` and drives `drdy_n` low on the next cycle. Completing a full read of the result register sets `drdy_n` high. The result register is read-only: a write to it shifts in 16 dummy bits that change nothing. `drdy_n` resets high.
- R9: There are three offset/gain pairs. Offset and gain accesses use the pair chosen by the channel field of their own command. Channel 3 uses the same pair as channel 2.
- R10: `cs_n` high aborts a partial access without committing it and returns the block to waiting for a command. `miso` is 0 while `cs_n` is high.
- R11: The test register is an 8-bit read/write register that resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| res_in | input | RES_W | New conversion result |
| res_valid | input | 1 | Strobe that loads `res_in` |
| drdy_n | output | 1 | Low while an unread result is held |
| pwr_down | output | 1 | Power-down request |
| chan | output | 2 | Selected input channel |
| setup_cfg | output | 8 | Setup register contents |
| clock_cfg | output | 8 | Clock register contents |

## Verification
The bench builds the block with the default widths: a 16-bit result, 24-bit offset and gain words, and three calibration pairs. These values exercise all three shift lengths and the clamping of channel 3 onto the last pair. Random command bytes cover every select code, both directions and every channel, including the ignored code 7. Result strobes placed between transfers exercise the data-ready handshake from both sides.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int RES_W = 16,
  parameter int CAL_W = 24,
  parameter int NPAIR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  input  logic [RES_W-1:0] res_in,
  input  logic             res_valid,
  output logic             drdy_n,
  output logic             pwr_down,
  output logic [1:0]       chan,
  output logic [7:0]       setup_cfg,
  output logic [7:0]       clock_cfg
);
  localparam int SH_W   = CAL_W;
  localparam int CNT_W  = $clog2(SH_W + 1);
  localparam int ID_BIT = 4;
  localparam logic [1:0] LAST_PAIR = 2'(NPAIR - 1);

  logic             sclk_q, busy, miso_q;
  logic [CNT_W-1:0] bcnt, len;
  logic [6:0]       cmd_sh, cmd_q;
  logic [SH_W-1:0]  rx_sh, tx_sh, rd_word, wv;
  logic [RES_W-1:0] res_q;
  logic [7:0]       test_q;
  logic [CAL_W-1:0] off_r [NPAIR];
  logic [CAL_W-1:0] gain_r [NPAIR];
  logic [7:0]       nb;
  logic [1:0]       npi, pi;

  wire rise = sclk & ~sclk_q & ~cs_n;
  wire fall = ~sclk & sclk_q & ~cs_n;

  assign nb     = {cmd_sh, mosi};
  assign npi    = (nb[1:0] > LAST_PAIR) ? LAST_PAIR : nb[1:0];
  assign pi     = (cmd_q[1:0] > LAST_PAIR) ? LAST_PAIR : cmd_q[1:0];
  assign wv     = {rx_sh[SH_W-2:0], mosi};
  assign pwr_down = cmd_q[2];
  assign chan   = cmd_q[1:0];
  assign miso   = ~cs_n & miso_q;

  always_comb begin
    case (cmd_q[6:4])
      3'd3:      len = CNT_W'(RES_W);
      3'd5, 3'd6: len = CNT_W'(CAL_W);
      default:   len = CNT_W'(8);
    endcase
  end

  always_comb begin
    rd_word = '0;
    case (nb[6:4])
      3'd0: rd_word = {drdy_n, nb[6:0], {(SH_W-8){1'b0}}};
      3'd1: rd_word = {setup_cfg, {(SH_W-8){1'b0}}};
      3'd2: rd_word = {clock_cfg, {(SH_W-8){1'b0}}};
      3'd3: rd_word = {res_q, {(SH_W-RES_W){1'b0}}};
      3'd4: rd_word = {test_q, {(SH_W-8){1'b0}}};
      3'd5: rd_word = off_r[npi];
      3'd6: rd_word = gain_r[npi];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b1;
      busy      <= 1'b0;
      miso_q    <= 1'b0;
      bcnt      <= '0;
      cmd_sh    <= '0;
      cmd_q     <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      res_q     <= '0;
      test_q    <= '0;
      drdy_n    <= 1'b1;
      setup_cfg <= 8'h01;
      clock_cfg <= 8'h10;
      for (int i = 0; i < NPAIR; i++) begin
        off_r[i]  <= '0;
        gain_r[i] <= '0;
      end
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        busy   <= 1'b0;
        bcnt   <= '0;
        miso_q <= 1'b0;
      end else if (rise && !busy) begin
        if (bcnt != '0 || !mosi) begin
          cmd_sh <= nb[6:0];
          bcnt   <= bcnt + 1'b1;
          if (bcnt == CNT_W'(7)) begin
            bcnt <= '0;
            if (nb[6:4] != 3'd7) begin
              cmd_q <= nb[6:0];
              if (nb[6:4] != 3'd0 || nb[3]) begin
                busy  <= 1'b1;
                tx_sh <= rd_word;
              end
            end
          end
        end
      end else if (rise && busy) begin
        rx_sh <= wv;
        bcnt  <= bcnt + 1'b1;
        if (bcnt == len - 1'b1) begin
          busy <= 1'b0;
          bcnt <= '0;
          if (cmd_q[3]) begin
            if (cmd_q[6:4] == 3'd3) drdy_n <= 1'b1;
          end else begin
            case (cmd_q[6:4])
              3'd1: setup_cfg  <= wv[7:0];
              3'd2: clock_cfg  <= wv[7:0] | 8'(1 << ID_BIT);
              3'd4: test_q     <= wv[7:0];
              3'd5: off_r[pi]  <= wv[CAL_W-1:0];
              3'd6: gain_r[pi] <= wv[CAL_W-1:0];
              default: ;
            endcase
          end
        end
      end else if (fall && busy && cmd_q[3]) begin
        miso_q <= tx_sh[SH_W-1];
        tx_sh  <= {tx_sh[SH_W-2:0], 1'b0};
      end
      if (res_valid) begin
        res_q  <= res_in;
        drdy_n <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       res_valid,
  input logic       drdy_n,
  input logic       pwr_down,
  input logic [1:0] chan,
  input logic [7:0] clock_cfg
);
  AST_RESULT_FLAGS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !drdy_n); // R8
  AST_READY_RELEASE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> $past(!cs_n)); // R8
  AST_ID_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    clock_cfg[4]); // R7
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso); // R10
  AST_FIELDS_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(pwr_down) && $stable(chan)); // R3
endmodule

bind serial_reg_port serial_reg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .res_valid(res_valid),
  .drdy_n(drdy_n), .pwr_down(pwr_down), .chan(chan), .clock_cfg(clock_cfg));

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
  logic clk = 0, rst_n = 0, sclk = 1, cs_n = 1, mosi = 0, res_valid = 0;
  logic [15:0] res_in = '0;
  logic miso, drdy_n, pwr_down;
  logic [1:0] chan;
  logic [7:0] setup_cfg, clock_cfg;
  int total = 0, bad = 0;
  bit finished = 0;

  serial_reg_port dut (.*);

  always #4 clk = ~clk;

  logic [6:0]  m_cmd;
  logic        m_drdy;
  logic [7:0]  m_setup, m_clk, m_test;
  logic [15:0] m_res;
  logic [23:0] m_off [3], m_gain [3];

  function automatic int width_of(input logic [2:0] rs);
    return rs == 3 ? 16 : (rs == 5 || rs == 6) ? 24 : 8;
  endfunction

  function automatic int pair_of(input logic [1:0] ch);
    return ch == 3 ? 2 : int'(ch);
  endfunction

  function automatic logic [23:0] model_read(input logic [7:0] c);
    case (c[6:4])
      3'd0: return {16'h0, m_drdy, c[6:0]};
      3'd1: return {16'h0, m_setup};
      3'd2: return {16'h0, m_clk};
      3'd3: return {8'h0, m_res};
      3'd4: return {16'h0, m_test};
      3'd5: return m_off[pair_of(c[1:0])];
      3'd6: return m_gain[pair_of(c[1:0])];
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o);
    @(negedge clk); sclk = 0; mosi = b;
    repeat (4) @(negedge clk);
    o = miso; sclk = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] c, input logic [23:0] wd, output logic [23:0] rd);
    logic o;
    int n;
    rd = '0;
    for (int i = 7; i >= 0; i--) bit_io(c[i], o);
    if (c[6:4] == 3'd7 || (c[6:4] == 3'd0 && !c[3])) return;
    n = width_of(c[6:4]);
    for (int i = n - 1; i >= 0; i--) begin
      bit_io(wd[i], o);
      rd = {rd[22:0], o};
    end
  endtask

  task automatic model_txn(input logic [7:0] c, input logic [23:0] wd, output logic [23:0] exp);
    exp = '0;
    if (c[6:4] == 3'd7) return;
    m_cmd = c[6:0];
    if (c[3]) begin
      exp = model_read(c);
      if (c[6:4] == 3'd3) m_drdy = 1;
    end else begin
      case (c[6:4])
        3'd1: m_setup = wd[7:0];
        3'd2: m_clk = wd[7:0] | 8'h10;
        3'd4: m_test = wd[7:0];
        3'd5: m_off[pair_of(c[1:0])] = wd;
        3'd6: m_gain[pair_of(c[1:0])] = wd;
        default: ;
      endcase
    end
  endtask

  task automatic run(input string req, input logic [7:0] c, input logic [23:0] wd);
    logic [23:0] rd, exp;
    int n;
    n = width_of(c[6:4]);
    model_txn(c, n == 24 ? wd : n == 16 ? {8'h0, wd[15:0]} : {16'h0, wd[7:0]}, exp);
    txn(c, wd, rd);
    if (c[3] && c[6:4] != 3'd7) chk({req, " read"}, rd, exp);
    chk({req, " fields R3"}, {21'h0, pwr_down, chan}, {21'h0, m_cmd[2], m_cmd[1:0]});
    chk({req, " setup R6"}, {16'h0, setup_cfg}, {16'h0, m_setup});
    chk({req, " clock R7"}, {16'h0, clock_cfg}, {16'h0, m_clk});
    chk({req, " drdy R8"}, {23'h0, drdy_n}, {23'h0, m_drdy});
  endtask

  task automatic new_result(input logic [15:0] v);
    @(negedge clk); res_in = v; res_valid = 1;
    @(negedge clk); res_valid = 0;
    m_res = v; m_drdy = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic o;
    logic [23:0] rd;
    void'($urandom(32'h5eed1234));
    m_cmd = '0; m_drdy = 1; m_setup = 8'h01; m_clk = 8'h10; m_test = '0; m_res = '0;
    for (int i = 0; i < 3; i++) begin m_off[i] = '0; m_gain[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset drdy R8", {23'h0, drdy_n}, 24'h1);
    chk("reset fields R3", {21'h0, pwr_down, chan}, 24'h0);
    chk("reset setup R6", {16'h0, setup_cfg}, 24'h01);
    chk("reset clock R7", {16'h0, clock_cfg}, 24'h10);
    chk("reset miso R10", {23'h0, miso}, 24'h0);
    cs_n = 0;
    run("setup default R6", 8'b0_001_1_0_00, 0);
    run("clock default R7", 8'b0_010_1_0_00, 0);
    run("test default R11", 8'b0_100_1_0_00, 0);
    for (int i = 0; i < 3; i++) bit_io(1'b1, o);
    run("leading ones R1", 8'b0_000_0_1_10, 0);
    run("comm read R4", 8'b0_000_1_1_10, 0);
    run("code 7 ignored R2", 8'b0_111_1_0_01, 0);
    run("after code 7 R2", 8'b0_000_1_1_10, 0);
    run("clock id write 0 R7", 8'b0_010_0_0_00, 24'h00);
    run("clock id read R7", 8'b0_010_1_0_00, 0);
    run("clock id write EF R7", 8'b0_010_0_0_00, 24'hEF);
    run("clock read back R7", 8'b0_010_1_0_00, 0);
    run("test write R11", 8'b0_100_0_0_00, 24'hA5);
    run("test read R11", 8'b0_100_1_0_00, 0);
    new_result(16'hBEEF);
    run("drdy in status R4", 8'b0_000_1_0_00, 0);
    run("data dummy write R8", 8'b0_011_0_0_00, 24'h1234);
    run("data read R5", 8'b0_011_1_0_00, 0);
    run("status after read R4", 8'b0_000_1_0_00, 0);
    run("offset ch2 write R9", 8'b0_101_0_0_10, 24'hC0FFEE);
    run("offset ch3 read R9", 8'b0_101_1_0_11, 0);
    run("gain ch0 write R9", 8'b0_110_0_0_00, 24'h123456);
    run("gain ch1 read R9", 8'b0_110_1_0_01, 0);
    run("gain ch0 read R9", 8'b0_110_1_0_00, 0);
    for (int i = 0; i < 8; i++) bit_io(i == 3 || i == 4, o);
    for (int i = 0; i < 4; i++) bit_io(1'b0, o);
    @(negedge clk); cs_n = 1;
    repeat (3) @(negedge clk);
    chk("abort miso R10", {23'h0, miso}, 24'h0);
    cs_n = 0;
    run("abort no commit R10", 8'b0_001_1_0_00, 0);
    for (int k = 0; k < 80; k++) begin
      logic [7:0] c;
      c = {1'b0, 3'($urandom % 8), 1'($urandom), 1'($urandom), 2'($urandom)};
      if ($urandom % 4 == 0) new_result(16'($urandom));
      run("random R5", c, 24'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule